// File: doc/BRIEF.md
# Buck Regulator Start-Up and Protection Sequencer

This block is the digital sequencer that sits above the analog loop of a synchronous step-down regulator. It decides when the converter may switch. It supplies the digital soft-start reference code. It pulls the output down through the low-side switch and a discharge path while the regulator is off. Its inputs are an enable and the flags from the supply, temperature, feedback and current comparators. From these it walks a state machine through off, reference wake-up, soft start and regulation, and it forces the machine off on a supply or temperature fault.

While switching is allowed, the block also produces the switching-cycle tick. While feedback sits below the short-circuit level, that tick is folded down to one in three clock cycles. The block masks the high-side switch for the rest of the current switching cycle whenever the overcurrent comparator trips. All inputs are level flags that are already synchronous to `clk`. There is no data stream, so every pin is a plain control or status level.

Top module: `buck_seq_ctrl`

## Requirements
- R1: During and directly after reset the block is off: `ss_ref_o`=0, `sw_en_o`=0, `dischg_en_o`=1, `ls_force_o`=1, `div3_sel_o`=0, `sw_tick_o`=0, `hs_off_o`=1.
- R2: When `en_i` is seen high in the off state (with `uvlo_i` and `ot_hot_i` low), `sw_en_o` first reads high WAKE_CYCLES+1 clock edges later. No switching is allowed during the wake-up wait.
- R3: During soft start, `ss_ref_o` starts at 0 and rises by exactly one every STEP_CYCLES clocks. It saturates at the all-ones code. One clock after it reaches all-ones the block is in regulation and the code holds. `sw_en_o` is high in both soft start and regulation.
- R4: `en_i` low (with no fault) during wake-up, soft start or regulation returns the block to off on the next edge. Off means `sw_en_o`=0, `ss_ref_o`=0, `hs_off_o`=1, and `ls_force_o`=`dischg_en_o`=1.
- R5: `uvlo_i` high forces the off state on the next edge from any state, ahead of every other input, and the block stays off while it is high.
- R6: `ot_hot_i` high (with `uvlo_i` low) enters a thermal-off state on the next edge, whatever `en_i` is. In thermal-off, `sw_en_o`, `dischg_en_o` and `ls_force_o` are all 0. The block stays there until `ot_hot_i` is low and `ot_cool_i` is high. It then goes to soft start from code 0 with no wake-up wait if `en_i` is high, and to off otherwise.
- R7: `div3_sel_o` takes the value of `fb_low_i` only on a tick clock or while not switching. While it is 1, ticks are exactly three clocks apart, so a change of the request never shortens or stretches a switching period.
- R8: While switching with `div3_sel_o`=0, `sw_tick_o` is high every clock. `sw_tick_o` is never high while `sw_en_o` is 0.
- R9: `hs_off_o` goes high in the same cycle as `oc_trip_i` while switching. It stays high until the next `sw_tick_o`, and is released in that tick cycle unless `oc_trip_i` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Regulator enable request |
| uvlo_i | input | 1 | Supply below lockout threshold |
| ot_hot_i | input | 1 | Die temperature at shutdown level |
| ot_cool_i | input | 1 | Die temperature at release level |
| fb_low_i | input | 1 | Feedback below short-circuit level |
| oc_trip_i | input | 1 | High-side peak-current comparator tripped |
| ss_ref_o | output | RAMP_BITS | Soft-start reference code |
| sw_en_o | output | 1 | Switching allowed |
| dischg_en_o | output | 1 | Output discharge path on |
| ls_force_o | output | 1 | Force low-side switch on |
| div3_sel_o | output | 1 | Switching clock folded by three |
| sw_tick_o | output | 1 | Start of a switching cycle |
| hs_off_o | output | 1 | High-side switch must be off |

## Verification
The assertions take for granted that the fault flags are clean synchronous levels. In particular, `ot_cool_i` means the die is below the release point, and a hot-to-cool release is decided by `ot_hot_i` falling before `ot_cool_i` rises. The directed stimulus respects this ordering. The random phase toggles each flag independently and at low probability, because the sequencer must give a defined answer for every combination, including a cool flag while still hot.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAKE  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_REG   = 3'd3,
    ST_THERM = 3'd4
  } seq_state_e;
endpackage

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_seq_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 30000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       uvlo_i,
  input  logic       ot_hot_i,
  input  logic       ot_cool_i,
  input  logic       ramp_full_i,
  output seq_state_e state_o
);
  localparam int unsigned WCW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WCW-1:0] WAKE_LAST = WCW'(WAKE_CYCLES - 1);

  seq_state_e st_q, st_d;
  logic [WCW-1:0] wake_cnt;

  always_comb begin
    st_d = st_q;
    if (uvlo_i) begin
      st_d = ST_OFF;
    end else if (ot_hot_i) begin
      st_d = ST_THERM;
    end else begin
      case (st_q)
        ST_OFF:   if (en_i) st_d = ST_WAKE;
        ST_WAKE:  if (!en_i) st_d = ST_OFF;
                  else if (wake_cnt == WAKE_LAST) st_d = ST_SOFT;
        ST_SOFT:  if (!en_i) st_d = ST_OFF;
                  else if (ramp_full_i) st_d = ST_REG;
        ST_REG:   if (!en_i) st_d = ST_OFF;
        ST_THERM: if (ot_cool_i) st_d = en_i ? ST_SOFT : ST_OFF;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      wake_cnt <= '0;
    end else begin
      st_q     <= st_d;
      wake_cnt <= (st_q == ST_WAKE && st_d == ST_WAKE) ? wake_cnt + 1'b1 : '0;
    end
  end

  assign state_o = st_q;

  // R5: lockout wins over everything
  a_r5_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (st_q == ST_OFF));
  // R6: hot flag enters thermal-off
  a_r6_hot_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_hot_i && !uvlo_i) |=> (st_q == ST_THERM));
  // R6: no release without the cool flag
  a_r6_therm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_THERM && !ot_cool_i && !uvlo_i) |=> (st_q == ST_THERM));
  // R4: disable from an active state
  a_r4_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !uvlo_i && !ot_hot_i &&
     (st_q == ST_WAKE || st_q == ST_SOFT || st_q == ST_REG)) |=> (st_q == ST_OFF));
endmodule

// File: rtl/buck_ss_ramp.sv
module buck_ss_ramp #(
  parameter int unsigned RAMP_BITS   = 8,
  parameter int unsigned STEP_CYCLES = 431
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en_i,
  input  logic                 keep_i,
  output logic [RAMP_BITS-1:0] ref_o,
  output logic                 full_o
);
  localparam int unsigned SCW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [SCW-1:0] STEP_LAST = SCW'(STEP_CYCLES - 1);

  logic [RAMP_BITS-1:0] ref_q;
  logic [SCW-1:0]       step_cnt;

  assign full_o = &ref_q;
  assign ref_o  = ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      step_cnt <= '0;
    end else if (step_en_i) begin
      if (step_cnt == STEP_LAST) begin
        step_cnt <= '0;
        if (!full_o) ref_q <= ref_q + 1'b1;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end else if (keep_i) begin
      step_cnt <= '0;
    end else begin
      ref_q    <= '0;
      step_cnt <= '0;
    end
  end

  // R3: code moves only by one step up or back to zero
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q != $past(ref_q)) |-> ((ref_q == $past(ref_q) + 1'b1) || (ref_q == '0)));
  // R3: full scale is sticky while ramping
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && full_o) |=> full_o);
endmodule

// File: rtl/buck_clk_fold.sv
module buck_clk_fold (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fold_req_i,
  output logic tick_o,
  output logic fold_o
);
  logic [1:0] ph_q;
  logic       fold_q;

  assign tick_o = run_i && (!fold_q || ph_q == 2'd2);
  assign fold_o = fold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      fold_q <= 1'b0;
    end else if (!run_i || tick_o) begin
      ph_q   <= '0;
      fold_q <= fold_req_i;
    end else begin
      ph_q   <= ph_q + 1'b1;
    end
  end

  // R7: folded ticks are three clocks apart
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && fold_req_i && run_i) |=> !tick_o ##1 !tick_o);
  // R7: select changes only at a cycle boundary
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_o) |=> $stable(fold_q));
endmodule

// File: rtl/buck_oc_block.sv
module buck_oc_block (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic oc_trip_i,
  output logic hs_off_o
);
  logic blk_q;
  logic carry;

  assign carry    = blk_q && !tick_i;
  assign hs_off_o = !run_i || oc_trip_i || carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else        blk_q <= run_i && (oc_trip_i || carry);
  end

  // R9: a trip keeps the high side off until the next cycle starts
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip_i && run_i) |=> (hs_off_o || tick_i || !run_i));
endmodule

// File: rtl/buck_seq_ctrl.sv
module buck_seq_ctrl
  import buck_seq_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 30000,
  parameter int unsigned RAMP_BITS   = 8,
  parameter int unsigned STEP_CYCLES = 431
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 uvlo_i,
  input  logic                 ot_hot_i,
  input  logic                 ot_cool_i,
  input  logic                 fb_low_i,
  input  logic                 oc_trip_i,
  output logic [RAMP_BITS-1:0] ss_ref_o,
  output logic                 sw_en_o,
  output logic                 dischg_en_o,
  output logic                 ls_force_o,
  output logic                 div3_sel_o,
  output logic                 sw_tick_o,
  output logic                 hs_off_o
);
  seq_state_e           state;
  logic                 run, ramp_full;
  logic [RAMP_BITS-1:0] ramp_code;

  buck_seq_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
    .ot_hot_i(ot_hot_i), .ot_cool_i(ot_cool_i),
    .ramp_full_i(ramp_full), .state_o(state)
  );

  buck_ss_ramp #(.RAMP_BITS(RAMP_BITS), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .step_en_i(state == ST_SOFT), .keep_i(state == ST_REG),
    .ref_o(ramp_code), .full_o(ramp_full)
  );

  assign run = (state == ST_SOFT) || (state == ST_REG);

  buck_clk_fold u_fold (
    .clk(clk), .rst_n(rst_n), .run_i(run), .fold_req_i(fb_low_i),
    .tick_o(sw_tick_o), .fold_o(div3_sel_o)
  );

  buck_oc_block u_oc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(sw_tick_o),
    .oc_trip_i(oc_trip_i), .hs_off_o(hs_off_o)
  );

  assign sw_en_o     = run;
  assign ss_ref_o    = run ? ramp_code : '0;
  assign dischg_en_o = (state == ST_OFF);
  assign ls_force_o  = (state == ST_OFF);

  // R8: no switching tick while switching is disallowed
  a_r8_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en_o |-> !sw_tick_o);
  // R4: the off state pulls the output down and blocks the high side
  a_r4_off_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    dischg_en_o |-> (ls_force_o && hs_off_o && ss_ref_o == '0));
endmodule

// File: tb/tb_buck_seq_ctrl.sv
module tb_buck_seq_ctrl;
  localparam int W  = 5;
  localparam int RB = 3;
  localparam int SC = 2;
  localparam int MAXREF = (1 << RB) - 1;

  logic clk = 1'b0;
  logic rst_n, en, uvlo, hot, cool, fb, oc;
  logic [RB-1:0] ss_ref;
  logic sw_en, dischg, lsf, div3, tick, hsoff;

  always #5 clk = ~clk;

  buck_seq_ctrl #(.WAKE_CYCLES(W), .RAMP_BITS(RB), .STEP_CYCLES(SC)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .ot_hot_i(hot),
    .ot_cool_i(cool), .fb_low_i(fb), .oc_trip_i(oc),
    .ss_ref_o(ss_ref), .sw_en_o(sw_en), .dischg_en_o(dischg), .ls_force_o(lsf),
    .div3_sel_o(div3), .sw_tick_o(tick), .hs_off_o(hsoff)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model: 0 off, 1 wake, 2 soft, 3 regulate, 4 thermal-off
  int ms, wc, sc, rf, ph;
  bit fa, blk;

  always @(posedge clk or negedge rst_n) begin
    int ns;
    bit run, tk;
    if (!rst_n) begin
      ms = 0; wc = 0; sc = 0; rf = 0; ph = 0; fa = 0; blk = 0;
    end else begin
      run = (ms == 2 || ms == 3);
      tk  = run && (!fa || ph == 2);
      ns  = ms;
      if (uvlo) ns = 0;
      else if (hot) ns = 4;
      else if (ms == 0) begin if (en) ns = 1; end
      else if (ms == 1) begin if (!en) ns = 0; else if (wc == W - 1) ns = 2; end
      else if (ms == 2) begin if (!en) ns = 0; else if (rf == MAXREF) ns = 3; end
      else if (ms == 3) begin if (!en) ns = 0; end
      else if (cool) ns = en ? 2 : 0;
      if (ms == 2) begin
        if (sc == SC - 1) begin sc = 0; if (rf < MAXREF) rf++; end else sc++;
      end else if (ms == 3) sc = 0;
      else begin rf = 0; sc = 0; end
      wc  = (ms == 1 && ns == 1) ? wc + 1 : 0;
      blk = run && (oc || (blk && !tk));
      if (!run || tk) begin ph = 0; fa = fb; end else ph++;
      ms = ns;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit run, tk, hx;
    run = (ms == 2 || ms == 3);
    tk  = run && (!fa || ph == 2);
    hx  = !run || oc || (blk && !tk);
    chk("R3", "ss_ref", ss_ref, run ? rf : 0);
    chk("R3", "sw_en", sw_en, run);
    chk("R4", "dischg", dischg, ms == 0);
    chk("R4", "ls_force", lsf, ms == 0);
    chk("R7", "div3_sel", div3, fa);
    chk("R8", "sw_tick", tick, tk);
    chk("R9", "hs_off", hsoff, hx);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual 200000 cycles expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; en = 0; uvlo = 0; hot = 0; cool = 0; fb = 0; oc = 0;
    cyc(3);
    // R1 reset state
    chk("R1", "ss_ref", ss_ref, 0);   chk("R1", "sw_en", sw_en, 0);
    chk("R1", "dischg", dischg, 1);   chk("R1", "ls_force", lsf, 1);
    chk("R1", "div3", div3, 0);       chk("R1", "tick", tick, 0);
    chk("R1", "hs_off", hsoff, 1);
    rst_n = 1;
    cyc(2);
    chk("R1", "sw_en after reset", sw_en, 0);

    // R2 wake delay, start-up with foldback active
    fb = 1; en = 1;
    n = 0;
    do begin cyc(); n++; end while (!sw_en && n < 50);
    chk("R2", "cycles to switching", n, W + 1);
    chk("R3", "ramp start code", ss_ref, 0);
    cyc(6);
    oc = 1; cyc(); oc = 0; cyc(4);        // R9 in folded mode
    fb = 0; cyc(25);
    chk("R3", "full scale in regulation", ss_ref, MAXREF);
    oc = 1; cyc(); oc = 0; cyc();
    chk("R9", "released at next tick", hsoff, 0);
    fb = 1; cyc(4); oc = 1; cyc(); oc = 0; cyc(5); fb = 0; cyc(3);

    // R4 disable
    en = 0; cyc();
    chk("R4", "sw_en", sw_en, 0); chk("R4", "dischg", dischg, 1);
    chk("R4", "ls_force", lsf, 1); chk("R4", "ss_ref", ss_ref, 0);
    cyc(3);

    // R6 thermal cycle
    en = 1; cyc(W + 5);
    hot = 1; cyc();
    chk("R6", "sw_en", sw_en, 0); chk("R6", "dischg", dischg, 0); chk("R6", "ls_force", lsf, 0);
    cyc(3); hot = 0; cyc(4);
    chk("R6", "held without cool", sw_en, 0);
    cool = 1; cyc(); cool = 0;
    chk("R6", "resume switching", sw_en, 1); chk("R6", "resume code", ss_ref, 0);
    cyc(30);

    // R5 lockout
    uvlo = 1; cyc();
    chk("R5", "sw_en", sw_en, 0); chk("R5", "dischg", dischg, 1);
    cyc(3); uvlo = 0; cyc(W + 20);
    hot = 1; cyc(2); uvlo = 1; cyc(2);
    chk("R5", "over thermal", dischg, 1);
    hot = 0; uvlo = 0; cyc(3);

    // random flag activity
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 99) < 3) en = ~en;
      if ($urandom_range(0, 99) < 1) uvlo = ~uvlo;
      if ($urandom_range(0, 99) < 1) hot = ~hot;
      cool = ($urandom_range(0, 99) < 10);
      if ($urandom_range(0, 99) < 5) fb = ~fb;
      oc = ($urandom_range(0, 99) < 8);
      cyc();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule